// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Sync Fill

This block turns bytes into a serial bit stream. A byte written into the holding register moves into the shift stage at the next character boundary. That frees the holding register for the following byte while the current one is still going out. Two character formats are available. The asynchronous format frames every character with a start bit and a stop period. The byte-synchronous format sends characters back to back with no framing. When the synchronous format has no data ready, it keeps the line busy by sending a programmed sync character.

All timing comes from a transmit-clock strobe, `tx_tick`, that pulses for one system clock per transmit clock edge. In divide-by-1 mode each bit lasts one strobe. In divide-by-16 mode each bit lasts `OVS` strobes. The configuration inputs are taken as static while a character is in flight. Word length, parity and format are read when a character is loaded into the shift stage.

Top module: `serial_tx_dbuf`

## Requirements
- R1: After reset `tx_line` is 1, `tx_ready` is 1 and `underrun` is 0.
- R2: In asynchronous mode (`cfg_sync`=0) a character is a 0 start bit followed by 5+`cfg_len` data bits, least significant first. Data bits above that length are ignored.
- R3: With `cfg_par_en`=1 a parity bit follows the data bits. With `cfg_par_odd`=0 the data bits plus parity hold an even number of ones; with `cfg_par_odd`=1 they hold an odd number. With `cfg_par_en`=0 no parity bit is sent.
- R4: `cfg_stop` sets the stop period: 0 gives 1 bit time, 1 gives 1.5 bit times and 2 or 3 gives 2 bit times. In divide-by-16 mode that is 16, 24 or 32 strobes. In divide-by-1 mode it is 1, 2 or 2 strobes.
- R5: Every bit lasts 1 strobe when `cfg_div16`=0 and `OVS` strobes when `cfg_div16`=1. `tx_line` changes only on cycles where `tx_tick` is 1. From idle, the start bit appears on the first strobe after the write.
- R6: In asynchronous mode the line is held at 1 while no character is being sent.
- R7: A write into an empty holding register drops `tx_ready` on the next clock. `tx_ready` rises again on the strobe that moves the byte into the shift stage. A byte that is waiting starts on the strobe that ends the previous stop period, with no idle gap.
- R8: A write while `tx_ready` is 0 is ignored. The byte already held is the one that gets sent.
- R9: In synchronous mode (`cfg_sync`=1) characters carry no start or stop bits. Each character is the data bits plus the optional parity bit, and characters follow one another with no gap.
- R10: In synchronous mode, if the holding register is empty at a character boundary, the sync character `sync_char` is sent instead. `underrun` is 1 from the strobe that loads a fill character and returns to 0 when a data character is loaded.
- R11: With parity enabled, the sync character is treated differently depending on word length. With an 8-bit word it gets a computed parity bit like data does. With a shorter word, the low 5+`cfg_len`+1 bits of `sync_char` are sent as they are, so its top sent bit stands in for parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_tick | input | 1 | One-cycle strobe per transmit clock edge |
| cfg_sync | input | 1 | 1 = byte-synchronous format, 0 = asynchronous |
| cfg_div16 | input | 1 | 1 = OVS strobes per bit, 0 = one strobe per bit |
| cfg_len | input | 2 | Word length code, length = 5 + code |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop | input | 2 | Stop period code: 0 = 1, 1 = 1.5, 2 or 3 = 2 bit times |
| sync_char | input | 8 | Fill character for synchronous underrun |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| tx_line | output | 1 | Serial output |
| tx_ready | output | 1 | Holding register is empty |
| underrun | output | 1 | Current synchronous character is a fill character |

## Verification
Most internal faults show up on the line within one character. A wrong bit count, parity term or stop length shifts every later sample, so comparing the whole stream against an arithmetically built expectation catches it on the first affected character. Faults in the holding register show on `tx_ready` one clock after a write, or as a missing or duplicated character in a back-to-back pair. In synchronous mode, a wrong boundary decision shows as a fill character where data was expected, and `underrun` disagrees at that character's first strobe.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_STOP} tx_state_e;

  typedef struct packed {
    logic [10:0] bits;
    logic [3:0]  nbits;
  } frame_t;

  // Assemble one character, bit 0 first on the line.
  function automatic frame_t build_frame(input logic [7:0] d, input logic [1:0] len_code,
                                         input logic par_en, input logic par_odd,
                                         input logic add_start, input logic raw_extra);
    frame_t      f;
    logic [7:0]  dm;
    logic [8:0]  word;
    int unsigned len;
    int unsigned n;
    len = 5 + int'(len_code);
    for (int i = 0; i < 8; i++) dm[i] = (i < len) ? d[i] : 1'b0;
    word = {1'b0, dm};
    n    = len;
    if (raw_extra) begin
      word[len] = d[len];
      n = len + 1;
    end else if (par_en) begin
      word[len] = (^dm) ^ par_odd;
      n = len + 1;
    end
    if (add_start) begin
      f.bits  = {1'b0, word, 1'b0};
      f.nbits = 4'(n + 1);
    end else begin
      f.bits  = {2'b00, word};
      f.nbits = 4'(n);
    end
    return f;
  endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  output logic          full,
  output logic [DW-1:0] data,
  output logic          ready
);
  logic nxt_full;
  logic accept;

  always_comb begin
    accept   = wr_stb && (pop || !full);
    nxt_full = pop ? wr_stb : (full || wr_stb);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= 1'b0;
      ready <= 1'b1;
    end else begin
      full  <= nxt_full;
      ready <= !nxt_full;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) data <= wr_data;
  end
endmodule

// File: rtl/sertx_timer.sv
module sertx_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = tick && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (tick) begin
      if (clear || done) cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sertx_engine.sv
module sertx_engine import sertx_pkg::*; #(
  parameter int OVS = 16,
  parameter int CW  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cfg_sync,
  input  logic          cfg_div16,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic [1:0]    cfg_stop,
  input  logic [7:0]    sync_char,
  input  logic          hold_full,
  input  logic [7:0]    hold_data,
  input  logic          tm_done,
  output logic          tm_clear,
  output logic [CW-1:0] tm_limit,
  output logic          pop,
  output logic          line,
  output logic          fill
);
  localparam logic [CW-1:0] BIT16  = CW'(OVS);
  localparam logic [CW-1:0] STOP15 = CW'(OVS + OVS / 2);
  localparam logic [CW-1:0] STOP2  = CW'(2 * OVS);

  tx_state_e     state;
  logic [10:0]   frm;
  logic [3:0]    left;
  logic [CW-1:0] bit_ticks;
  logic [CW-1:0] stop_ticks;
  logic          boundary;
  logic          raw_sc;
  frame_t        nf;

  always_comb begin
    bit_ticks = cfg_div16 ? BIT16 : CW'(1);
    if (cfg_div16) begin
      case (cfg_stop)
        2'd0:    stop_ticks = BIT16;
        2'd1:    stop_ticks = STOP15;
        default: stop_ticks = STOP2;
      endcase
    end else begin
      stop_ticks = (cfg_stop == 2'd0) ? CW'(1) : CW'(2);
    end
    tm_limit = (state == ST_STOP) ? stop_ticks : bit_ticks;
    tm_clear = (state == ST_IDLE);
    boundary = tick && ((state == ST_IDLE) ||
               (tm_done && (state == ST_STOP ||
                            (state == ST_SHIFT && left == 4'd1 && cfg_sync))));
    pop      = boundary && hold_full;
    raw_sc   = !hold_full && cfg_sync && cfg_par_en && (cfg_len != 2'd3);
    nf       = build_frame(hold_full ? hold_data : sync_char, cfg_len, cfg_par_en,
                           cfg_par_odd, !cfg_sync, raw_sc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      line  <= 1'b1;
      fill  <= 1'b0;
      frm   <= '0;
      left  <= '0;
    end else if (boundary) begin
      if (hold_full || cfg_sync) begin
        state <= ST_SHIFT;
        frm   <= nf.bits;
        left  <= nf.nbits;
        line  <= nf.bits[0];
        fill  <= !hold_full;
      end else begin
        state <= ST_IDLE;
        line  <= 1'b1;
      end
    end else if (state == ST_SHIFT && tm_done) begin
      if (left == 4'd1) begin
        state <= ST_STOP;
        line  <= 1'b1;
      end else begin
        frm  <= frm >> 1;
        line <= frm[1];
        left <= left - 4'd1;
      end
    end
  end
endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_tick,
  input  logic       cfg_sync,
  input  logic       cfg_div16,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [1:0] cfg_stop,
  input  logic [7:0] sync_char,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  output logic       tx_line,
  output logic       tx_ready,
  output logic       underrun
);
  localparam int CW = $clog2(2 * OVS + 1);

  logic          hold_full;
  logic [7:0]    hold_data;
  logic          pop;
  logic          tm_done;
  logic          tm_clear;
  logic [CW-1:0] tm_limit;

  sertx_hold #(.DW(8)) hold_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .pop(pop),
    .full(hold_full), .data(hold_data), .ready(tx_ready)
  );

  sertx_timer #(.CW(CW)) timer_i (
    .clk(clk), .rst(rst), .tick(tx_tick), .clear(tm_clear), .limit(tm_limit),
    .done(tm_done)
  );

  sertx_engine #(.OVS(OVS), .CW(CW)) engine_i (
    .clk(clk), .rst(rst), .tick(tx_tick), .cfg_sync(cfg_sync), .cfg_div16(cfg_div16),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .sync_char(sync_char), .hold_full(hold_full),
    .hold_data(hold_data), .tm_done(tm_done), .tm_clear(tm_clear), .tm_limit(tm_limit),
    .pop(pop), .line(tx_line), .fill(underrun)
  );
endmodule

// File: rtl/serial_tx_dbuf_chk.sv
module serial_tx_dbuf_chk (
  input logic clk,
  input logic rst,
  input logic tx_tick,
  input logic cfg_sync,
  input logic wr_stb,
  input logic tx_line,
  input logic tx_ready,
  input logic underrun
);
  // R5
  line_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_tick |=> $stable(tx_line));

  // R7
  write_fills_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && tx_ready) |=> !tx_ready);

  // R7
  drain_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_tick && !tx_ready) |=> !tx_ready);

  // R10
  fill_sync_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> $past(cfg_sync) && $past(tx_tick));

  // R10
  fill_moves_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_tick |=> $stable(underrun));
endmodule

bind serial_tx_dbuf serial_tx_dbuf_chk chk_i (
  .clk(clk), .rst(rst), .tx_tick(tx_tick), .cfg_sync(cfg_sync), .wr_stb(wr_stb),
  .tx_line(tx_line), .tx_ready(tx_ready), .underrun(underrun)
);

// File: tb/serial_tx_dbuf_tb_top.sv
`timescale 1ns/1ps
module serial_tx_dbuf_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       cfg_sync = 1'b0;
  logic       cfg_div16 = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic [1:0] cfg_stop = 2'd0;
  logic [7:0] sync_ch = 8'h00;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tx_line, tx_ready, underrun;

  int checks = 0;
  int errors = 0;
  int nexp = 0;
  logic exp_l [0:1023];
  logic got_l [0:1023];
  logic got_u [0:1023];

  always #2 clk = ~clk;

  serial_tx_dbuf #(.OVS(16)) dut_i (
    .clk(clk), .rst(rst), .tx_tick(tick), .cfg_sync(cfg_sync), .cfg_div16(cfg_div16),
    .cfg_len(cfg_len), .cfg_par_en(par_en), .cfg_par_odd(par_odd), .cfg_stop(cfg_stop),
    .sync_char(sync_ch), .wr_stb(wr_stb), .wr_data(wr_data), .tx_line(tx_line),
    .tx_ready(tx_ready), .underrun(underrun)
  );

  task automatic check1(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic tick1(input int idx);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    got_l[idx] = tx_line;
    got_u[idx] = underrun;
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk) begin wr_stb = 1'b1; wr_data = d; end
    @(negedge clk) wr_stb = 1'b0;
  endtask

  task automatic push_n(input logic v, input int cnt);
    for (int k = 0; k < cnt; k++) begin
      exp_l[nexp] = v;
      nexp++;
    end
  endtask

  // Expected stream for one character, derived from R2, R3, R4, R9, R11.
  task automatic push_char(input logic [7:0] d, input int lc, input bit pe, input bit po,
                           input bit with_start, input bit raw, input int b, input int s);
    int len, ones;
    len = 5 + lc;
    ones = 0;
    if (with_start) push_n(1'b0, b);
    for (int i = 0; i < len; i++) begin
      ones += int'(d[i]);
      push_n(d[i], b);
    end
    if (raw) push_n(d[len], b);
    else if (pe) push_n(logic'((ones % 2) == 1) ^ logic'(po), b);
    if (with_start) push_n(1'b1, s);
  endtask

  task automatic check_stream(input string req, input int n);
    int bad_idx;
    bad_idx = -1;
    for (int i = 0; i < n; i++)
      if (bad_idx < 0 && got_l[i] !== exp_l[i]) bad_idx = i;
    checks++;
    if (bad_idx >= 0) begin
      errors++;
      $display("FAIL %s: tick %0d line got %0b expected %0b", req, bad_idx,
               got_l[bad_idx], exp_l[bad_idx]);
    end
  endtask

  task automatic sync_case(input bit d16, input int lc, input bit pe, input bit po,
                           input logic [7:0] sc, input logic [7:0] data);
    int b, ns, nd;
    bit raw;
    b = d16 ? 16 : 1;
    raw = pe && (lc != 3);
    ns = (5 + lc + ((raw || pe) ? 1 : 0)) * b;
    nd = (5 + lc + (pe ? 1 : 0)) * b;
    @(negedge clk) begin
      cfg_sync = 1'b1; cfg_div16 = d16; cfg_len = 2'(lc); par_en = pe; par_odd = po;
      sync_ch = sc;
    end
    do_reset();
    nexp = 0;
    push_char(sc, lc, pe, po, 1'b0, raw, b, 0);
    push_char(data, lc, pe, po, 1'b0, 1'b0, b, 0);
    push_char(sc, lc, pe, po, 1'b0, raw, b, 0);
    push_char(sc, lc, pe, po, 1'b0, raw, b, 0);
    for (int i = 0; i < 3; i++) tick1(i);
    write_byte(data);
    check1("R7", tx_ready, 1'b0, "sync ready after write");
    for (int i = 3; i < nexp; i++) tick1(i);
    check_stream("R9 R11 sync stream", nexp);
    check1("R10", got_u[0], 1'b1, "underrun on first fill");
    check1("R10", got_u[ns], 1'b0, "underrun on data char");
    check1("R10", got_u[ns + nd], 1'b1, "underrun on refill");
    check1("R7", tx_ready, 1'b1, "sync ready after load");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check1("R1", tx_line, 1'b1, "line after reset");
    check1("R1", tx_ready, 1'b1, "ready after reset");
    check1("R1", underrun, 1'b0, "underrun after reset");

    // Asynchronous sweep over all lengths, parity modes, stop codes and both rates.
    for (int dv = 0; dv < 2; dv++)
      for (int lc = 0; lc < 4; lc++)
        for (int pm = 0; pm < 3; pm++)
          for (int st = 0; st < 3; st++) begin
            logic [7:0] d;
            int b, s;
            d = 8'(197 + lc * 29 + pm * 7 + st * 3 + dv * 101);
            b = dv ? 16 : 1;
            s = dv ? ((st == 0) ? 16 : (st == 1) ? 24 : 32) : ((st == 0) ? 1 : 2);
            @(negedge clk) begin
              cfg_div16 = dv[0]; cfg_len = 2'(lc); par_en = (pm != 0); par_odd = (pm == 2);
              cfg_stop = 2'(st);
            end
            nexp = 0;
            push_char(d, lc, pm != 0, pm == 2, 1'b1, 1'b0, b, s);
            push_n(1'b1, 2);
            write_byte(d);
            check1("R7", tx_ready, 1'b0, "ready after write");
            for (int i = 0; i < nexp; i++) tick1(i);
            check_stream("R2 R3 R4 R5 R6 async frame", nexp);
            check1("R7", tx_ready, 1'b1, "ready after frame");
          end

    // Stop code 3 behaves as two bit times (R4).
    @(negedge clk) begin cfg_div16 = 1'b0; cfg_len = 2'd1; par_en = 1'b0; cfg_stop = 2'd3; end
    nexp = 0;
    push_char(8'h2B, 1, 1'b0, 1'b0, 1'b1, 1'b0, 1, 2);
    push_n(1'b1, 2);
    write_byte(8'h2B);
    for (int i = 0; i < nexp; i++) tick1(i);
    check_stream("R4 stop code 3", nexp);

    // Back-to-back characters through the holding register (R7).
    @(negedge clk) begin cfg_len = 2'd3; par_en = 1'b1; par_odd = 1'b0; cfg_stop = 2'd2; end
    nexp = 0;
    push_char(8'h96, 3, 1'b1, 1'b0, 1'b1, 1'b0, 1, 2);
    push_char(8'h0F, 3, 1'b1, 1'b0, 1'b1, 1'b0, 1, 2);
    push_n(1'b1, 3);
    write_byte(8'h96);
    tick1(0);
    check1("R7", tx_ready, 1'b1, "ready once first byte loaded");
    write_byte(8'h0F);
    check1("R7", tx_ready, 1'b0, "ready after second write");
    for (int i = 1; i < nexp; i++) tick1(i);
    check_stream("R7 back-to-back", nexp);

    // Write while full is dropped (R8).
    nexp = 0;
    push_char(8'h21, 3, 1'b1, 1'b0, 1'b1, 1'b0, 1, 2);
    push_n(1'b1, 4);
    write_byte(8'h21);
    write_byte(8'hFE);
    check1("R8", tx_ready, 1'b0, "ready while holding");
    for (int i = 0; i < nexp; i++) tick1(i);
    check_stream("R8 second write ignored", nexp);
    check1("R8", tx_ready, 1'b1, "ready after only frame");

    // Synchronous format with fill characters.
    sync_case(1'b0, 2, 1'b1, 1'b0, 8'hD3, 8'h5A);
    sync_case(1'b0, 3, 1'b1, 1'b1, 8'h4E, 8'h81);
    sync_case(1'b1, 0, 1'b0, 1'b0, 8'h15, 8'h0A);
    sync_case(1'b0, 1, 1'b1, 1'b1, 8'hB2, 8'h3C);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule